// File: doc/BRIEF.md
# Trap and Interrupt Entry Sequencer

This block carries a 16-bit processor into a service routine and back out of it again. Each trip is a short sequence of single-word memory transfers. A start pulse selects one of three operations:

- **Trap entry.** The 8-bit vector comes from the instruction.
- **Interrupt entry.** The vector and the 3-bit priority come from the interrupt arbiter.
- **Return.** This undoes either kind of entry.

At a start pulse the block samples the current PC, PSR and R6 from the core. When the sequence ends, the block presents the new PC, PSR and R6 and raises a one-cycle done pulse.

The block holds the two shadow stack pointers, one for user mode and one for supervisor mode. On entry from user mode it parks the user R6 and switches to the supervisor stack before any push. It then writes the old PSR and the incremented PC downward on that stack. It reads the routine start address from one of two vector tables, one base for traps and one for interrupts, and loads PC from it. A return pops PC and then PSR. If the popped PSR is in user mode, it parks the supervisor pointer and brings back the user one.

PSR layout: bit 15 is privilege (0 supervisor, 1 user), bits [10:8] are priority (0 lowest, 7 highest), and bits [2:0] are condition codes.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset the block is idle: busy, done and mem_req are 0, saved_ssp_o equals SSP_INIT and saved_usp_o equals USP_INIT.
- R2: On entry with cur_psr[15]=1, saved_usp_o takes cur_r6 and the stack used is the supervisor shadow. On entry with cur_psr[15]=0, the stack used is cur_r6 and both shadows stay unchanged.
- R3: Entry pushes cur_psr at stack-1 first, then cur_pc at stack-2; each push decrements R6 by one before its write, so r6_o ends two below the stack start.
- R4: A trap clears PSR bit 15 and keeps every other PSR bit. PC becomes the word read at TRAP_BASE plus the zero-extended 8-bit vector.
- R5: An interrupt sets PSR to bit 15 = 0, bits [10:8] = request priority, bits [2:0] = 3'b010, with all other bits 0. PC becomes the word read at INTR_BASE (0x0100 by default) plus the vector.
- R6: Return reads PC from address cur_r6 and then PSR from cur_r6+1; each pop increments R6 after the read.
- R7: When the popped PSR has bit 15 = 1, saved_ssp_o takes the post-pop R6 and r6_o takes saved_usp_o. When bit 15 is 0, both shadows are left unchanged.
- R8: busy is 1 from the cycle after an accepted start until done. done is a single-cycle pulse, raised while pc_o, psr_o and r6_o already hold their final values.
- R9: A start request while busy is 1 is ignored. When several start inputs are 1 together in idle, interrupt wins over trap and trap wins over return.
- R10: mem_req stays 1 with mem_addr, mem_we and mem_wdata stable until mem_ack. Each ack completes exactly one transfer, with read data taken from mem_rdata in the ack cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_trap | input | 1 | Begin trap entry (sampled in idle) |
| start_intr | input | 1 | Begin interrupt entry (sampled in idle) |
| start_rti | input | 1 | Begin return (sampled in idle) |
| trap_vec | input | 8 | Trap vector from the instruction |
| intr_vec | input | 8 | Interrupt vector from the arbiter |
| intr_pri | input | 3 | Priority of the interrupt request |
| cur_pc | input | 16 | Incremented PC of the running program |
| cur_psr | input | 16 | PSR of the running program |
| cur_r6 | input | 16 | Current stack pointer R6 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Resulting PC |
| psr_o | output | 16 | Resulting PSR |
| r6_o | output | 16 | Resulting R6 |
| saved_usp_o | output | 16 | User shadow stack pointer |
| saved_ssp_o | output | 16 | Supervisor shadow stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Transfer word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer acknowledge |

## Verification
The bench builds the block with SSP_INIT = 0x0300 and USP_INIT = 0x0200, and keeps the default table bases 0x0000 and 0x0100. This places the supervisor stack, the trap table and the interrupt table inside a 1024-word bench memory, so every pushed word can be read back directly. The vector table holds 0x0400 plus its own address, which makes each routine start address prove which base and vector were used. Acknowledge latency varies from zero to three wait cycles, which exercises the request-hold rule. The bench runs a nested sequence: a user-mode interrupt, then a supervisor-mode trap inside it, then two returns. This covers both the swapping and the non-swapping paths.

// File: rtl/tes_pkg.sv
package tes_pkg;

    localparam int WORD_W   = 16;
    localparam int VEC_W    = 8;
    localparam int PRI_W    = 3;
    localparam int CC_W     = 3;
    localparam int PRIV_BIT = 15;
    localparam int PRI_LSB  = 8;
    localparam logic [CC_W-1:0] INTR_CC = 3'b010;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        K_NONE,
        K_TRAP,
        K_INTR,
        K_RTI
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PSR,
        ST_PUSH_PC,
        ST_VEC,
        ST_POP_PC,
        ST_POP_PSR,
        ST_RESTORE,
        ST_DONE
    } state_e;

    typedef enum logic [2:0] {
        SP_HOLD,
        SP_ENTRY,
        SP_RTI,
        SP_DEC,
        SP_INC,
        SP_RESTORE
    } sp_op_e;

    // PSR presented to the service routine on entry
    function automatic word_t entry_psr(input kind_e k, input word_t cur,
                                        input logic [PRI_W-1:0] pri);
        word_t r;
        if (k == K_INTR) begin
            r = '0;
            r[PRI_LSB +: PRI_W] = pri;
            r[CC_W-1:0] = INTR_CC;
        end else begin
            r = cur;
        end
        r[PRIV_BIT] = 1'b0;
        return r;
    endfunction

    function automatic word_t table_addr(input word_t base, input logic [VEC_W-1:0] vec);
        return base + word_t'(vec);
    endfunction

endpackage

// File: rtl/tes_fsm.sv
module tes_fsm
    import tes_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_trap,
    input  logic   start_intr,
    input  logic   start_rti,
    input  logic   mem_ack,
    input  logic   restored_priv,
    output state_e state,
    output kind_e  kind,
    output kind_e  sel_kind,
    output logic   accept,
    output sp_op_e sp_op
);

    state_e nxt;

    // fixed arbitration: interrupt, then trap, then return
    always_comb begin
        if (start_intr)      sel_kind = K_INTR;
        else if (start_trap) sel_kind = K_TRAP;
        else if (start_rti)  sel_kind = K_RTI;
        else                 sel_kind = K_NONE;
    end

    assign accept = (state == ST_IDLE) && (sel_kind != K_NONE);

    always_comb begin
        nxt   = state;
        sp_op = SP_HOLD;
        case (state)
            ST_IDLE: if (accept) begin
                if (sel_kind == K_RTI) begin
                    nxt   = ST_POP_PC;
                    sp_op = SP_RTI;
                end else begin
                    nxt   = ST_PUSH_PSR;
                    sp_op = SP_ENTRY;
                end
            end
            ST_PUSH_PSR: if (mem_ack) begin nxt = ST_PUSH_PC; sp_op = SP_DEC; end
            ST_PUSH_PC:  if (mem_ack) begin nxt = ST_VEC;     sp_op = SP_DEC; end
            ST_VEC:      if (mem_ack) nxt = ST_DONE;
            ST_POP_PC:   if (mem_ack) begin nxt = ST_POP_PSR; sp_op = SP_INC; end
            ST_POP_PSR:  if (mem_ack) begin nxt = ST_RESTORE; sp_op = SP_INC; end
            ST_RESTORE: begin
                nxt   = ST_DONE;
                sp_op = restored_priv ? SP_RESTORE : SP_HOLD;
            end
            ST_DONE:     nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            kind  <= K_NONE;
        end else begin
            state <= nxt;
            if (accept) kind <= sel_kind;
        end
    end

endmodule

// File: rtl/tes_sp_bank.sv
module tes_sp_bank
    import tes_pkg::*;
#(
    parameter word_t SSP_INIT = 16'h3000,
    parameter word_t USP_INIT = 16'hFDFF
) (
    input  logic   clk,
    input  logic   rst,
    input  sp_op_e op,
    input  word_t  cur_r6,
    input  logic   cur_priv,
    output word_t  sp,
    output word_t  usp,
    output word_t  ssp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp  <= '0;
            usp <= USP_INIT;
            ssp <= SSP_INIT;
        end else begin
            case (op)
                SP_ENTRY: begin
                    if (cur_priv) begin
                        usp <= cur_r6;
                        sp  <= ssp;
                    end else begin
                        sp  <= cur_r6;
                    end
                end
                SP_RTI:     sp <= cur_r6;
                SP_DEC:     sp <= sp - 1'b1;
                SP_INC:     sp <= sp + 1'b1;
                SP_RESTORE: begin
                    ssp <= sp;
                    sp  <= usp;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
    import tes_pkg::*;
#(
    parameter logic [15:0] TRAP_BASE = 16'h0000,
    parameter logic [15:0] INTR_BASE = 16'h0100,
    parameter logic [15:0] SSP_INIT  = 16'h3000,
    parameter logic [15:0] USP_INIT  = 16'hFDFF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_trap,
    input  logic        start_intr,
    input  logic        start_rti,
    input  logic [7:0]  trap_vec,
    input  logic [7:0]  intr_vec,
    input  logic [2:0]  intr_pri,
    input  logic [15:0] cur_pc,
    input  logic [15:0] cur_psr,
    input  logic [15:0] cur_r6,
    output logic        busy,
    output logic        done,
    output logic [15:0] pc_o,
    output logic [15:0] psr_o,
    output logic [15:0] r6_o,
    output logic [15:0] saved_usp_o,
    output logic [15:0] saved_ssp_o,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    input  logic        mem_ack
);

    state_e state;
    kind_e  kind, sel_kind;
    sp_op_e sp_op;
    logic   accept;

    word_t             pc_q, psr_q, hold_psr, hold_pc, sp;
    logic [VEC_W-1:0]  vec_q;
    logic [PRI_W-1:0]  pri_q;

    tes_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_trap   (start_trap),
        .start_intr   (start_intr),
        .start_rti    (start_rti),
        .mem_ack      (mem_ack),
        .restored_priv(psr_q[PRIV_BIT]),
        .state        (state),
        .kind         (kind),
        .sel_kind     (sel_kind),
        .accept       (accept),
        .sp_op        (sp_op)
    );

    tes_sp_bank #(
        .SSP_INIT(SSP_INIT),
        .USP_INIT(USP_INIT)
    ) u_sp (
        .clk     (clk),
        .rst     (rst),
        .op      (sp_op),
        .cur_r6  (cur_r6),
        .cur_priv(cur_psr[PRIV_BIT]),
        .sp      (sp),
        .usp     (saved_usp_o),
        .ssp     (saved_ssp_o)
    );

    // architectural results and values captured at start
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            psr_q    <= '0;
            hold_psr <= '0;
            hold_pc  <= '0;
            vec_q    <= '0;
            pri_q    <= '0;
        end else begin
            if (accept) begin
                hold_psr <= cur_psr;
                hold_pc  <= cur_pc;
                vec_q    <= (sel_kind == K_INTR) ? intr_vec : trap_vec;
                pri_q    <= intr_pri;
            end
            if (mem_ack) begin
                case (state)
                    ST_VEC: begin
                        pc_q  <= mem_rdata;
                        psr_q <= entry_psr(kind, hold_psr, pri_q);
                    end
                    ST_POP_PC:  pc_q  <= mem_rdata;
                    ST_POP_PSR: psr_q <= mem_rdata;
                    default: ;
                endcase
            end
        end
    end

    // memory request multiplexer
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_PUSH_PSR: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = sp - 1'b1; mem_wdata = hold_psr;
            end
            ST_PUSH_PC: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = sp - 1'b1; mem_wdata = hold_pc;
            end
            ST_VEC: begin
                mem_req  = 1'b1;
                mem_addr = table_addr((kind == K_INTR) ? INTR_BASE : TRAP_BASE, vec_q);
            end
            ST_POP_PC, ST_POP_PSR: begin
                mem_req  = 1'b1;
                mem_addr = sp;
            end
            default: ;
        endcase
    end

    assign busy  = (state != ST_IDLE);
    assign done  = (state == ST_DONE);
    assign pc_o  = pc_q;
    assign psr_o = psr_q;
    assign r6_o  = sp;

endmodule

// File: rtl/tes_checks.sv
module tes_checks (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic [15:0] r6_o
);

    // R10: request held stable until acknowledged
    a_r10_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: no memory traffic when idle
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R3: every push targets the word below the current stack pointer
    a_r3_push_below: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == r6_o - 16'd1));

    // R3: an acknowledged push lowers R6 by one
    a_r3_push_dec: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack) |=> (r6_o == $past(r6_o) - 16'd1));

endmodule

bind trap_entry_seq tes_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .r6_o     (r6_o)
);

// File: tb/sim_trap_entry_seq.sv
module sim_trap_entry_seq;

    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYCLES = 20000;
    localparam logic [15:0] SSP0 = 16'h0300;
    localparam logic [15:0] USP0 = 16'h0200;

    typedef struct packed {
        logic [1:0]  kind;   // 0 trap, 1 interrupt, 2 return
        logic [7:0]  vec;
        logic [2:0]  pri;
        logic [15:0] pc;
        logic [15:0] psr;
        logic [15:0] r6;
        logic [15:0] e_pc;
        logic [15:0] e_psr;
        logic [15:0] e_r6;
        logic [15:0] e_usp;
        logic [15:0] e_ssp;
        logic [1:0]  lat;
    } row_t;

    // table word at address a holds 0x0400 + a
    localparam row_t ROWS [0:7] = '{
        '{2'd0, 8'h23, 3'd0, 16'h3001, 16'h8102, 16'h5000, 16'h0423, 16'h0102, 16'h02FE, 16'h5000, 16'h0300, 2'd0},
        '{2'd2, 8'h00, 3'd0, 16'h0000, 16'h0000, 16'h02FE, 16'h3001, 16'h8102, 16'h5000, 16'h5000, 16'h0300, 2'd1},
        '{2'd1, 8'h80, 3'd5, 16'h0450, 16'h0304, 16'h0280, 16'h0580, 16'h0502, 16'h027E, 16'h5000, 16'h0300, 2'd2},
        '{2'd2, 8'h00, 3'd0, 16'h0000, 16'h0000, 16'h027E, 16'h0450, 16'h0304, 16'h0280, 16'h5000, 16'h0300, 2'd3},
        '{2'd1, 8'hFF, 3'd7, 16'h4000, 16'h8001, 16'h6000, 16'h05FF, 16'h0702, 16'h02FE, 16'h6000, 16'h0300, 2'd0},
        '{2'd0, 8'h00, 3'd0, 16'h0123, 16'h0607, 16'h02FE, 16'h0400, 16'h0607, 16'h02FC, 16'h6000, 16'h0300, 2'd1},
        '{2'd2, 8'h00, 3'd0, 16'h0000, 16'h0000, 16'h02FC, 16'h0123, 16'h0607, 16'h02FE, 16'h6000, 16'h0300, 2'd0},
        '{2'd2, 8'h00, 3'd0, 16'h0000, 16'h0000, 16'h02FE, 16'h4000, 16'h8001, 16'h6000, 16'h6000, 16'h0300, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start_trap, start_intr, start_rti;
    logic [7:0]  trap_vec, intr_vec;
    logic [2:0]  intr_pri;
    logic [15:0] cur_pc, cur_psr, cur_r6;
    logic        busy, done;
    logic [15:0] pc_o, psr_o, r6_o, saved_usp_o, saved_ssp_o;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata;
    logic        mem_ack;

    logic [15:0] mem [0:1023];
    int lat;
    int wr_cnt;
    int checks;
    int fails;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_entry_seq #(
        .SSP_INIT(SSP0),
        .USP_INIT(USP0)
    ) u0 (
        .clk(clk), .rst(rst),
        .start_trap(start_trap), .start_intr(start_intr), .start_rti(start_rti),
        .trap_vec(trap_vec), .intr_vec(intr_vec), .intr_pri(intr_pri),
        .cur_pc(cur_pc), .cur_psr(cur_psr), .cur_r6(cur_r6),
        .busy(busy), .done(done),
        .pc_o(pc_o), .psr_o(psr_o), .r6_o(r6_o),
        .saved_usp_o(saved_usp_o), .saved_ssp_o(saved_ssp_o),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory responder with programmable wait cycles
    initial begin
        int wcnt;
        wcnt = 0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        wr_cnt = 0;
        for (int i = 0; i < 1024; i++) mem[i] = (i < 512) ? 16'(16'h0400 + i) : 16'h0000;
        forever begin
            @(posedge clk);
            if (mem_ack) begin
                mem_ack <= 1'b0;
            end else if (mem_req) begin
                if (wcnt >= lat) begin
                    wcnt = 0;
                    mem_ack <= 1'b1;
                    if (mem_we) begin
                        mem[mem_addr[9:0]] <= mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata <= mem[mem_addr[9:0]];
                    end
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic pulse(input int k);
        @(negedge clk);
        start_trap = (k == 0);
        start_intr = (k == 1);
        start_rti  = (k == 2);
        @(negedge clk);
        start_trap = 1'b0;
        start_intr = 1'b0;
        start_rti  = 1'b0;
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R8", "done seen", 16'(done), 16'd1);
    endtask

    initial begin
        repeat (WDOG_CYCLES) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired actual=busy expected=done");
        summary();
        $finish;
    end

    initial begin
        checks = 0; fails = 0; lat = 0;
        rst = 1'b1;
        start_trap = 0; start_intr = 0; start_rti = 0;
        trap_vec = 0; intr_vec = 0; intr_pri = 0;
        cur_pc = 0; cur_psr = 0; cur_r6 = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1", "busy", 16'(busy), 16'd0);
        chk("R1", "done", 16'(done), 16'd0);
        chk("R1", "mem_req", 16'(mem_req), 16'd0);
        chk("R1", "saved_ssp", saved_ssp_o, SSP0);
        chk("R1", "saved_usp", saved_usp_o, USP0);

        // table-driven nested entry/return sequence (R2..R7, R10 via latency)
        for (int r = 0; r < 8; r++) begin
            row_t v;
            v = ROWS[r];
            lat = int'(v.lat);
            trap_vec = v.vec; intr_vec = v.vec; intr_pri = v.pri;
            cur_pc = v.pc; cur_psr = v.psr; cur_r6 = v.r6;
            pulse(int'(v.kind));
            chk("R8", "busy after start", 16'(busy), 16'd1);
            wait_done();
            chk((v.kind == 2'd1) ? "R5" : (v.kind == 2'd0) ? "R4" : "R6", "pc", pc_o, v.e_pc);
            chk((v.kind == 2'd1) ? "R5" : (v.kind == 2'd0) ? "R4" : "R6", "psr", psr_o, v.e_psr);
            chk((v.kind == 2'd2) ? "R7" : "R3", "r6", r6_o, v.e_r6);
            chk((v.kind == 2'd2) ? "R7" : "R2", "saved_usp", saved_usp_o, v.e_usp);
            chk((v.kind == 2'd2) ? "R7" : "R2", "saved_ssp", saved_ssp_o, v.e_ssp);
            if (v.kind != 2'd2) begin
                chk("R3", "stacked psr", mem[10'(v.e_r6 + 16'd1)], v.psr);
                chk("R3", "stacked pc", mem[10'(v.e_r6)], v.pc);
            end
            @(negedge clk);
            chk("R8", "done pulse width", 16'(done), 16'd0);
            chk("R8", "idle after done", 16'(busy), 16'd0);
        end

        // R9: start while busy is ignored
        lat = 2;
        wr_cnt = 0;
        trap_vec = 8'h23; cur_pc = 16'h3005; cur_psr = 16'h8000; cur_r6 = 16'h5100;
        pulse(0);
        intr_vec = 8'h10; intr_pri = 3'd6; cur_psr = 16'h0000; cur_r6 = 16'h0111;
        pulse(1);
        wait_done();
        chk("R9", "pc unaffected by busy start", pc_o, 16'h0423);
        chk("R9", "psr unaffected", psr_o, 16'h0000);
        chk("R9", "writes", 16'(wr_cnt), 16'd2);
        repeat (3) @(negedge clk);
        chk("R9", "no late start", 16'(busy), 16'd0);
        chk("R2", "usp from user entry", saved_usp_o, 16'h5100);

        // R9: simultaneous requests, interrupt wins; supervisor entry keeps R6 path
        lat = 0;
        trap_vec = 8'h05; intr_vec = 8'h06; intr_pri = 3'd3;
        cur_pc = 16'h0777; cur_psr = 16'h0001; cur_r6 = 16'h0280;
        @(negedge clk);
        start_trap = 1'b1; start_intr = 1'b1; start_rti = 1'b1;
        @(negedge clk);
        start_trap = 1'b0; start_intr = 1'b0; start_rti = 1'b0;
        wait_done();
        chk("R9", "interrupt priority pc", pc_o, 16'h0506);
        chk("R5", "interrupt psr", psr_o, 16'h0302);
        chk("R2", "supervisor r6", r6_o, 16'h027E);
        chk("R2", "usp unchanged", saved_usp_o, 16'h5100);

        summary();
        $finish;
    end

endmodule